// File: doc/BRIEF.md
# Dual-I/O Serial Flash Command Front-End

This block is the slave-side command receiver of a serial flash device running with two data pins. It watches chip select, the serial clock and the pin pair DQ1/DQ0, all already synchronised to the on-chip clock. It takes in two bits on every rising serial-clock edge and decodes the opcode that starts each transaction. It also keeps the write-enable latch.

A page-program transaction is accepted only while the latch is set. For an accepted program, the block collects a 24-bit address and then passes each received data byte to a page buffer, together with its byte offset and a one-cycle valid strobe. When chip select is released cleanly, a commit pulse tells the array controller to program the buffered page. Reads, erases, the array itself, output drive and status polling belong to other blocks.

Top module: `dio_cmd_frontend`

## Requirements
- R1: Every serial-clock rising edge while chip select is low captures two bits. dq_i[1] is the higher (odd) bit of the pair and dq_i[0] the lower (even) bit, and the most significant pair comes first. An opcode therefore takes 4 edges, the address 12 edges and each data byte 4 edges.
- R2: Opcode 8'h06 sets the write-enable latch (wel_o=1). Opcode 8'h04 clears it. The new value appears in the cycle after the fourth edge is captured.
- R3: Opcodes 8'h02, 8'hA2 and 8'hD2 each start a page program, and all three behave identically.
- R4: A page-program opcode received while wel_o=0 is ignored. No byte strobe and no commit pulse follow, and wel_o is unchanged.
- R5: The address is captured from edges 4 to 15. Bits 23 and 22 are forced to zero in addr_o, which is updated one cycle after edge 15.
- R6: Each complete data byte of an accepted program produces exactly one cycle of pb_valid_o, one cycle after its fourth edge, with pb_data_o. The byte offset starts at address bits 7:0 and increments modulo 256, so a transfer of more than 256 bytes wraps and overwrites earlier offsets.
- R7: commit_o pulses for exactly one cycle, one cycle after chip select rises. It pulses only if the transaction was an accepted program, at least one byte was complete, and no partial byte was in progress. In every other case there is no pulse.
- R8: A commit clears wel_o in the same cycle that commit_o is high.
- R9: An opcode other than the five above causes the rest of the transaction to be ignored. Raising chip select restarts decoding at the opcode phase.
- R10: After reset, wel_o, pb_valid_o and commit_o are 0 and addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | On-chip clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| dq_i | input | 2 | Data pins: [1] odd bit, [0] even bit |
| wel_o | output | 1 | Write-enable latch |
| addr_o | output | 24 | Captured program address with the top two bits zeroed |
| pb_data_o | output | 8 | Data byte for the page buffer |
| pb_offset_o | output | 8 | Byte offset within the page |
| pb_valid_o | output | 1 | One-cycle strobe for a page-buffer write |
| commit_o | output | 1 | One-cycle program-commit pulse |

## Verification
Every result is due exactly one clk_i cycle after the event that causes it. A serial-clock edge driven at a falling clk_i edge is captured at the next rising edge, so wel_o, addr_o and the byte strobe are sampled at the falling edge that follows. Likewise, commit_o is sampled one falling edge after chip select is raised. The bench drives every input at falling edges and compares at exactly those points. A pair that does not complete a byte must leave pb_valid_o low. A random mix of opcodes, addresses, byte counts and trailing partial bytes is checked against a bench model of the latch and the page offset.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA, PH_SKIP} phase_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_PP_A = 8'h02;
  localparam logic [7:0] OP_PP_B = 8'hA2;
  localparam logic [7:0] OP_PP_C = 8'hD2;

  function automatic logic is_prog(logic [7:0] op);
    return (op == OP_PP_A) || (op == OP_PP_B) || (op == OP_PP_C);
  endfunction
endpackage

// File: rtl/dio_edge_det.sv
module dio_edge_det #(
  parameter int unsigned    WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] sig_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_q[i] <= RST_VAL[i];
      else         sig_q[i] <= sig_i[i];
    end
    assign rise_o[i] = sig_i[i] & ~sig_q[i];
  end
endmodule

// File: rtl/dio_pair_shift.sv
module dio_pair_shift #(
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic [1:0]        dq_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-3:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[BYTE_W-5:0], dq_i};
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // byte including the pair arriving this cycle
  assign byte_o = {sh_q, dq_i};
endmodule

// File: rtl/dio_cmd_frontend.sv
module dio_cmd_frontend #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned CNT_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [1:0]        dq_i,
  output logic              wel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        pb_data_o,
  output logic [PAGE_W-1:0] pb_offset_o,
  output logic              pb_valid_o,
  output logic              commit_o
);
  import dio_pkg::*;

  localparam int unsigned OP_LAST   = 3;
  localparam int unsigned ADDR_LAST = (8 + ADDR_W) / 2 - 1;
  localparam int unsigned MASK_W    = ADDR_W - 2;

  logic [1:0]        rise;
  logic              cs_rise, sclk_rise;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        byte_nxt;
  logic [ADDR_W-1:0] addr_sh;
  logic [PAGE_W-1:0] offset_q;
  logic              got_byte_q;
  phase_e            phase_q;

  dio_edge_det #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({cs_ni, sclk_i}),
    .rise_o (rise)
  );
  assign cs_rise   = rise[1];
  assign sclk_rise = rise[0] & ~cs_ni;

  dio_pair_shift #(.CNT_W(CNT_W), .BYTE_W(8)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cs_ni),
    .shift_i (sclk_rise),
    .dq_i    (dq_i),
    .cnt_o   (cnt),
    .byte_o  (byte_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_OP;
      wel_o       <= 1'b0;
      addr_o      <= '0;
      addr_sh     <= '0;
      offset_q    <= '0;
      got_byte_q  <= 1'b0;
      pb_data_o   <= '0;
      pb_offset_o <= '0;
      pb_valid_o  <= 1'b0;
      commit_o    <= 1'b0;
    end else begin
      pb_valid_o <= 1'b0;
      commit_o   <= 1'b0;
      // commit only on a clean byte boundary
      if (cs_rise && phase_q == PH_DATA && got_byte_q && cnt[1:0] == 2'd0) begin
        commit_o <= 1'b1;
        wel_o    <= 1'b0;
      end
      if (cs_ni) begin
        phase_q    <= PH_OP;
        got_byte_q <= 1'b0;
      end else if (sclk_rise) begin
        unique case (phase_q)
          PH_OP: if (cnt == CNT_W'(OP_LAST)) begin
            if (byte_nxt == OP_WREN) begin
              wel_o   <= 1'b1;
              phase_q <= PH_SKIP;
            end else if (byte_nxt == OP_WRDI) begin
              wel_o   <= 1'b0;
              phase_q <= PH_SKIP;
            end else if (is_prog(byte_nxt) && wel_o) begin
              phase_q <= PH_ADDR;
            end else begin
              phase_q <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            addr_sh <= {addr_sh[ADDR_W-3:0], dq_i};
            if (cnt == CNT_W'(ADDR_LAST)) begin
              addr_o   <= {2'b00, addr_sh[MASK_W-3:0], dq_i};
              offset_q <= {addr_sh[PAGE_W-3:0], dq_i};
              phase_q  <= PH_DATA;
            end
          end
          PH_DATA: if (cnt[1:0] == 2'd3) begin
            pb_valid_o  <= 1'b1;
            pb_data_o   <= byte_nxt;
            pb_offset_o <= offset_q;
            offset_q    <= offset_q + 1'b1;
            got_byte_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dio_cmd_frontend_chk.sv
module dio_cmd_frontend_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              wel_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              pb_valid_o,
  input logic              commit_o
);
  // R5
  addr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[ADDR_W-1:ADDR_W-2] == 2'b00);

  // R7
  commit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  // R7
  commit_on_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(cs_ni));

  // R8
  commit_clears_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !wel_o);

  // R4
  strobe_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_valid_o |-> wel_o);

  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_valid_o |=> !pb_valid_o);
endmodule

bind dio_cmd_frontend dio_cmd_frontend_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .wel_o      (wel_o),
  .addr_o     (addr_o),
  .pb_valid_o (pb_valid_o),
  .commit_o   (commit_o)
);

// File: tb/dio_cmd_frontend_bench.sv
module dio_cmd_frontend_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sclk_i = 1'b0;
  logic [1:0]  dq_i = 2'b00;
  logic        wel_o;
  logic [23:0] addr_o;
  logic [7:0]  pb_data_o;
  logic [7:0]  pb_offset_o;
  logic        pb_valid_o;
  logic        commit_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic        wel_m = 1'b0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  dio_cmd_frontend u_dio_cmd_frontend (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .dq_i(dq_i),
    .wel_o(wel_o), .addr_o(addr_o), .pb_data_o(pb_data_o),
    .pb_offset_o(pb_offset_o), .pb_valid_o(pb_valid_o), .commit_o(commit_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic prog_op(logic [7:0] op);
    return op == 8'h02 || op == 8'hA2 || op == 8'hD2;
  endfunction

  // one pair: outputs reflecting its capture are visible on return
  task automatic pair(logic [1:0] d);
    sclk_i = 1'b0; dq_i = d;
    @(negedge clk_i);
    sclk_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic txn(logic [7:0] op, logic [23:0] addr, int nbytes, int extra);
    logic accepted;
    logic [7:0] off;
    logic [7:0] b;
    accepted = prog_op(op) && wel_m;
    cs_ni = 1'b0;
    @(negedge clk_i);
    for (int i = 3; i >= 0; i--) pair(op[2*i+1 -: 2]);
    if (op == 8'h06) wel_m = 1'b1;
    else if (op == 8'h04) wel_m = 1'b0;
    chk("R2 wel after opcode", wel_o, wel_m);
    for (int i = 11; i >= 0; i--) pair(addr[2*i+1 -: 2]);
    if (accepted) chk("R5 masked address", addr_o, addr & 24'h3FFFFF);
    off = addr[7:0];
    for (int k = 0; k < nbytes; k++) begin
      b = 8'($urandom);
      for (int i = 3; i >= 1; i--) begin
        pair(b[2*i+1 -: 2]);
        chk("R6 no strobe mid-byte", pb_valid_o, 1'b0);
      end
      pair(b[1:0]);
      chk("R4/R6 byte strobe", pb_valid_o, accepted);
      if (accepted) begin
        chk("R1 byte data", pb_data_o, b);
        chk("R6 byte offset", pb_offset_o, off);
        off++;
      end
    end
    for (int i = 0; i < extra; i++) pair(2'($urandom));
    sclk_i = 1'b0;
    cs_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 commit", commit_o, accepted && nbytes > 0 && extra == 0);
    if (accepted && nbytes > 0 && extra == 0) wel_m = 1'b0;
    chk("R8 wel after end", wel_o, wel_m);
    @(negedge clk_i);
    chk("R7 commit single", commit_o, 1'b0);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    // R10
    chk("R10 reset wel", wel_o, 1'b0);
    chk("R10 reset strobe", pb_valid_o, 1'b0);
    chk("R10 reset commit", commit_o, 1'b0);
    chk("R10 reset addr", addr_o, 24'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    txn(8'h02, 24'h000010, 2, 0);      // R4 ignored, latch clear
    txn(8'h06, 24'h0, 0, 0);           // R2
    txn(8'h02, 24'hFF_12F3, 3, 0);     // R3 R5 R7 R8
    txn(8'h06, 24'h0, 0, 0);
    txn(8'hA2, 24'h40_00F0, 300, 0);   // R6 wrap past 256
    txn(8'h06, 24'h0, 0, 0);
    txn(8'hD2, 24'h81_0005, 2, 2);     // R7 partial byte: no commit
    chk("R8 wel kept without commit", wel_o, 1'b1);
    txn(8'h02, 24'h00_0000, 0, 0);     // R7 no bytes: no commit
    txn(8'h9F, 24'h12_3456, 2, 0);     // R9 unknown opcode
    chk("R9 wel kept after unknown", wel_o, 1'b1);
    txn(8'h04, 24'h0, 0, 0);           // R2 clear
    txn(8'hA2, 24'h00_0100, 1, 0);     // R4
    for (int t = 0; t < 60; t++) begin
      logic [7:0] op;
      int sel;
      sel = int'($urandom % 7);
      case (sel)
        0, 6: op = 8'h06;
        1: op = 8'h04;
        2: op = 8'h02;
        3: op = 8'hA2;
        4: op = 8'hD2;
        default: op = 8'($urandom);
      endcase
      txn(op, 24'($urandom), int'($urandom % 12), (($urandom % 4) == 0) ? int'($urandom % 4) : 0);
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule